// File: doc/BRIEF.md
# Persistent Tap-Setting Register Bank with Commit Timer

This block holds the stored settings of a four-channel digital potentiometer: each channel owns four 6-bit setting slots, sixteen in all. Flops stand in for the persistent cells. The command decoder hands over fully received write requests. A request is either a host write of one slot, a copy of one channel's live wiper position into one of its slots, or a copy of every channel's wiper position into the same slot index. The request is only staged. It becomes a real write when chip select rises at the end of that frame.

A commit starts a busy period measured in pulses of a slow timing tick. A status read reports the busy flag. While the flag is up, the slots keep their previous contents, and new requests from the decoder are discarded. The slots take the new values on the same clock edge on which the flag drops. A low level on the write-protect pin at the moment of commit cancels the write, and no busy period starts. Slot 0 of every channel is exported all the time, so the wiper logic can restore it at power-up.

Top module: `nvreg_bank`

## Requirements
- R1: After reset all sixteen slots read 0, `busy` is 0 and every field of `recall_vals` is 0.
- R2: A host write (`req_kind` = 0) to channel `req_pot`, slot `req_reg` is committed with `req_data` when it is followed in the same frame by a `cs_rise` pulse.
- R3: A staged request is discarded by a `cs_fall` pulse (start of a new frame), and no slot ever changes while `busy` is low.
- R4: A commit raises `busy` in the cycle after the `cs_rise` pulse. `busy` then stays high until exactly `BUSY_TICKS` `tick` pulses have been seen, and it falls on the clock edge that samples the last of them.
- R5: While `busy` is high, `rd_data` returns the old contents of the slot addressed by `rd_pot`/`rd_reg`. The new value appears in the same cycle that `busy` falls.
- R6: If `wp_n` is low when `cs_rise` arrives, the staged request is dropped, no slot changes and `busy` stays low.
- R7: A single transfer (`req_kind` = 1) writes the value of channel `req_pot` in `wiper_vals`, sampled when the request arrives, into slot `req_reg` of that channel.
- R8: A global transfer (`req_kind` = 2) writes every channel's `wiper_vals` field, sampled when the request arrives, into slot `req_reg` of that channel, all in one commit.
- R9: Requests that arrive while `busy` is high are dropped and cannot be committed by a later `cs_rise`.
- R10: `recall_vals` bits [6p+5:6p] always show slot 0 of channel p.
- R11: `req_kind` = 3 is not a request. It stages nothing, and a following `cs_rise` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle strobe: a complete write request from the decoder |
| req_kind | input | 2 | 0 host write, 1 single transfer, 2 global transfer, 3 none |
| req_pot | input | 2 | Channel select |
| req_reg | input | 2 | Slot select |
| req_data | input | 6 | Host write data |
| wiper_vals | input | 24 | Live wiper positions, channel p at bits [6p+5:6p] |
| cs_fall | input | 1 | One-cycle pulse at the start of a frame |
| cs_rise | input | 1 | One-cycle pulse at the end of a frame |
| wp_n | input | 1 | Write protect, low blocks commits |
| tick | input | 1 | Timing pulse counted by the busy timer |
| rd_pot | input | 2 | Read channel select |
| rd_reg | input | 2 | Read slot select |
| rd_data | output | 6 | Contents of the addressed slot |
| busy | output | 1 | Write-in-progress flag |
| recall_vals | output | 24 | Slot 0 of every channel, channel p at bits [6p+5:6p] |

## Verification
The assertions assume that `cs_fall`, `cs_rise` and `req_valid` are single-cycle pulses that never coincide, and that a request lies between a frame start and its frame end. The bench produces every frame through one task that pulses these strobes in separate cycles, in that order. `tick` is driven only by the bench, which leaves random gaps between pulses, so a busy period of several cycles must not end without a tick. `wp_n` changes only between frames, and it is held steady across each `cs_rise`.

// File: rtl/nvreg_pkg.sv
package nvreg_pkg;

    typedef enum logic [1:0] {
        KIND_HOST   = 2'd0,
        KIND_XFER   = 2'd1,
        KIND_GLOBAL = 2'd2,
        KIND_NONE   = 2'd3
    } req_kind_e;

    function automatic int sel_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/nvb_stage.sv
module nvb_stage
    import nvreg_pkg::*;
#(
    parameter int NUM_POTS = 4,
    parameter int NUM_REGS = 4,
    parameter int DW       = 6,
    localparam int PW      = sel_width(NUM_POTS),
    localparam int RW      = sel_width(NUM_REGS),
    localparam int VW      = NUM_POTS * DW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [1:0]          kind,
    input  logic [PW-1:0]       pot,
    input  logic [RW-1:0]       rsel,
    input  logic [DW-1:0]       host_data,
    input  logic [VW-1:0]       wiper_vals,
    input  logic                clear,
    output logic                pend,
    output logic [NUM_POTS-1:0] pend_mask,
    output logic [RW-1:0]       pend_reg,
    output logic [VW-1:0]       pend_vals
);

    typedef struct packed {
        logic [NUM_POTS-1:0] mask;
        logic [RW-1:0]       rsel;
        logic [VW-1:0]       vals;
    } stage_t;

    stage_t stg_d, stg_q;

    always_comb begin
        stg_d = stg_q;
        if (clear) begin
            stg_d.mask = '0;
        end
        if (load) begin
            stg_d.mask = '0;
            stg_d.rsel = rsel;
            for (int p = 0; p < NUM_POTS; p++) begin
                if (kind == KIND_GLOBAL) begin
                    stg_d.mask[p]          = 1'b1;
                    stg_d.vals[p*DW +: DW] = wiper_vals[p*DW +: DW];
                end else if (pot == PW'(p)) begin
                    stg_d.mask[p] = 1'b1;
                    if (kind == KIND_HOST) begin
                        stg_d.vals[p*DW +: DW] = host_data;
                    end else begin
                        stg_d.vals[p*DW +: DW] = wiper_vals[p*DW +: DW];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign pend      = |stg_q.mask;
    assign pend_mask = stg_q.mask;
    assign pend_reg  = stg_q.rsel;
    assign pend_vals = stg_q.vals;

endmodule

// File: rtl/nvb_timer.sv
module nvb_timer #(
    parameter int BUSY_TICKS = 10000,
    localparam int CW        = $clog2(BUSY_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic busy,
    output logic done
);

    localparam logic [CW-1:0] LAST = CW'(BUSY_TICKS - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        done  = tmr_q.busy && tick && (tmr_q.cnt == LAST);
        if (start) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = '0;
        end else if (tmr_q.busy && tick) begin
            if (tmr_q.cnt == LAST) begin
                tmr_d.busy = 1'b0;
                tmr_d.cnt  = '0;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign busy = tmr_q.busy;

endmodule

// File: rtl/nvb_store.sv
module nvb_store
    import nvreg_pkg::*;
#(
    parameter int NUM_POTS = 4,
    parameter int NUM_REGS = 4,
    parameter int DW       = 6,
    localparam int PW      = sel_width(NUM_POTS),
    localparam int RW      = sel_width(NUM_REGS),
    localparam int VW      = NUM_POTS * DW,
    localparam int CELLW   = NUM_POTS * NUM_REGS * DW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [NUM_POTS-1:0] load_mask,
    input  logic [RW-1:0]       load_reg,
    input  logic [VW-1:0]       load_vals,
    input  logic                apply,
    input  logic [PW-1:0]       rd_pot,
    input  logic [RW-1:0]       rd_reg,
    output logic [DW-1:0]       rd_data,
    output logic [VW-1:0]       recall_vals,
    output logic [CELLW-1:0]    cells_flat
);

    typedef struct packed {
        logic [NUM_POTS-1:0] mask;
        logic [RW-1:0]       rsel;
        logic [VW-1:0]       vals;
        logic [CELLW-1:0]    cells;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.mask = load_mask;
            st_d.rsel = load_reg;
            st_d.vals = load_vals;
        end
        if (apply) begin
            for (int p = 0; p < NUM_POTS; p++) begin
                if (st_q.mask[p]) begin
                    st_d.cells[(p*NUM_REGS + int'(st_q.rsel))*DW +: DW] =
                        st_q.vals[p*DW +: DW];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data = st_q.cells[(int'(rd_pot)*NUM_REGS + int'(rd_reg))*DW +: DW];
    end

    for (genvar p = 0; p < NUM_POTS; p++) begin : g_recall
        assign recall_vals[p*DW +: DW] = st_q.cells[(p*NUM_REGS)*DW +: DW];
    end

    assign cells_flat = st_q.cells;

endmodule

// File: rtl/nvreg_bank.sv
module nvreg_bank
    import nvreg_pkg::*;
#(
    parameter int NUM_POTS   = 4,
    parameter int NUM_REGS   = 4,
    parameter int DW         = 6,
    parameter int BUSY_TICKS = 10000,
    localparam int PW        = sel_width(NUM_POTS),
    localparam int RW        = sel_width(NUM_REGS),
    localparam int VW        = NUM_POTS * DW,
    localparam int CELLW     = NUM_POTS * NUM_REGS * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic [PW-1:0] req_pot,
    input  logic [RW-1:0] req_reg,
    input  logic [DW-1:0] req_data,
    input  logic [VW-1:0] wiper_vals,
    input  logic          cs_fall,
    input  logic          cs_rise,
    input  logic          wp_n,
    input  logic          tick,
    input  logic [PW-1:0] rd_pot,
    input  logic [RW-1:0] rd_reg,
    output logic [DW-1:0] rd_data,
    output logic          busy,
    output logic [VW-1:0] recall_vals
);

    logic                stage_pend;
    logic [NUM_POTS-1:0] stage_mask;
    logic [RW-1:0]       stage_reg;
    logic [VW-1:0]       stage_vals;
    logic                stage_load;
    logic                commit_go;
    logic                timer_done;
    logic [CELLW-1:0]    cells_flat;

    assign stage_load = req_valid && !busy && (req_kind != KIND_NONE);
    assign commit_go  = cs_rise && stage_pend && wp_n && !busy;

    nvb_stage #(
        .NUM_POTS (NUM_POTS),
        .NUM_REGS (NUM_REGS),
        .DW       (DW)
    ) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (stage_load),
        .kind       (req_kind),
        .pot        (req_pot),
        .rsel       (req_reg),
        .host_data  (req_data),
        .wiper_vals (wiper_vals),
        .clear      (cs_fall || cs_rise),
        .pend       (stage_pend),
        .pend_mask  (stage_mask),
        .pend_reg   (stage_reg),
        .pend_vals  (stage_vals)
    );

    nvb_timer #(
        .BUSY_TICKS (BUSY_TICKS)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (commit_go),
        .tick  (tick),
        .busy  (busy),
        .done  (timer_done)
    );

    nvb_store #(
        .NUM_POTS (NUM_POTS),
        .NUM_REGS (NUM_REGS),
        .DW       (DW)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (commit_go),
        .load_mask   (stage_mask),
        .load_reg    (stage_reg),
        .load_vals   (stage_vals),
        .apply       (timer_done),
        .rd_pot      (rd_pot),
        .rd_reg      (rd_reg),
        .rd_data     (rd_data),
        .recall_vals (recall_vals),
        .cells_flat  (cells_flat)
    );

endmodule

// File: rtl/nvreg_bank_chk.sv
module nvreg_bank_chk #(
    parameter int CELLW = 96
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_rise,
    input logic             wp_n,
    input logic             tick,
    input logic             busy,
    input logic             stage_pend,
    input logic [CELLW-1:0] cells_flat
);

    AST_COMMIT_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && stage_pend && wp_n && !busy) |=> busy); // R4

    AST_BUSY_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> busy); // R4

    AST_PROTECT_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && !wp_n && !busy) |=> !busy); // R6

    AST_IDLE_CELLS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(cells_flat)); // R3

    AST_BUSY_CELLS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(cells_flat) || !busy)); // R5

    AST_NO_STAGE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !stage_pend); // R9

endmodule

bind nvreg_bank nvreg_bank_chk #(
    .CELLW (CELLW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_rise    (cs_rise),
    .wp_n       (wp_n),
    .tick       (tick),
    .busy       (busy),
    .stage_pend (stage_pend),
    .cells_flat (cells_flat)
);

// File: tb/nvreg_bank_tb.sv
`timescale 1ns/1ps
module nvreg_bank_tb;

    localparam int NP = 4;
    localparam int NR = 4;
    localparam int DW = 6;
    localparam int BT = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_kind = '0;
    logic [1:0]    req_pot = '0;
    logic [1:0]    req_reg = '0;
    logic [DW-1:0] req_data = '0;
    logic [23:0]   wiper_vals = '0;
    logic          cs_fall = 1'b0;
    logic          cs_rise = 1'b0;
    logic          wp_n = 1'b1;
    logic          tick = 1'b0;
    logic [1:0]    rd_pot = '0;
    logic [1:0]    rd_reg = '0;
    logic [DW-1:0] rd_data;
    logic          busy;
    logic [23:0]   recall_vals;

    int total = 0;
    int bad   = 0;
    logic [DW-1:0] model [NP][NR];

    always #2.5 clk = ~clk;

    nvreg_bank #(
        .NUM_POTS (NP), .NUM_REGS (NR), .DW (DW), .BUSY_TICKS (BT)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_kind (req_kind),
        .req_pot (req_pot), .req_reg (req_reg), .req_data (req_data),
        .wiper_vals (wiper_vals), .cs_fall (cs_fall), .cs_rise (cs_rise),
        .wp_n (wp_n), .tick (tick), .rd_pot (rd_pot), .rd_reg (rd_reg),
        .rd_data (rd_data), .busy (busy), .recall_vals (recall_vals)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic read_chk(input int p, input int r, input int exp, input string tag);
        rd_pot = 2'(p);
        rd_reg = 2'(r);
        #0.1;
        chk(rd_data == DW'(exp), tag, rd_data, exp);
    endtask

    function automatic string kind_tag(input int k);
        case (k)
            0: return "R2";
            1: return "R7";
            2: return "R8";
            default: return "R11";
        endcase
    endfunction

    task automatic run_busy(input int p, input int r, input int oldv);
        for (int i = 0; i < BT; i++) begin
            int gap = $urandom_range(0, 2);
            for (int g = 0; g < gap; g++) begin
                step();
                chk(busy == 1'b1, "R4 busy holds without tick", busy, 1);
            end
            read_chk(p, r, oldv, "R5 old value during busy");
            tick = 1'b1;
            step();
            tick = 1'b0;
            chk(busy == (i != BT - 1), "R4 busy tick count", busy, (i != BT - 1));
        end
    endtask

    // mode 0: commit at frame end; mode 1: new frame starts before the frame end
    task automatic frame(input int kind, input int p, input int r, input int data,
                         input bit wp, input int mode);
        logic [DW-1:0] snap [NP];
        bit eff;
        string tag;
        wiper_vals = 24'($urandom);
        for (int q = 0; q < NP; q++) snap[q] = wiper_vals[q*DW +: DW];
        cs_fall = 1'b1; step(); cs_fall = 1'b0;
        req_valid = 1'b1; req_kind = 2'(kind); req_pot = 2'(p); req_reg = 2'(r);
        req_data = DW'(data);
        step();
        req_valid = 1'b0;
        wiper_vals = 24'($urandom);
        if (mode == 1) begin
            cs_fall = 1'b1; step(); cs_fall = 1'b0;
        end
        wp_n = wp;
        cs_rise = 1'b1; step(); cs_rise = 1'b0;
        eff = (mode == 0) && wp && (kind != 3);
        tag = (mode == 1) ? "R3" : (!wp ? "R6" : kind_tag(kind));
        chk(busy == eff, {tag, " busy after frame end"}, busy, eff);
        if (eff) begin
            run_busy(p, r, model[p][r]);
            for (int q = 0; q < NP; q++) begin
                if (kind == 2) model[q][r] = snap[q];
                else if (q == p) model[q][r] = (kind == 0) ? DW'(data) : snap[q];
            end
        end else begin
            repeat (3) step();
            chk(busy == 1'b0, {tag, " no busy"}, busy, 0);
        end
        for (int q = 0; q < NP; q++) begin
            read_chk(q, r, model[q][r], {tag, " slot contents"});
            chk(recall_vals[q*DW +: DW] == model[q][0], "R10 recall slot 0",
                recall_vals[q*DW +: DW], model[q][0]);
        end
        wp_n = 1'b1;
        step();
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int p = 0; p < NP; p++)
            for (int r = 0; r < NR; r++) model[p][r] = '0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(recall_vals == '0, "R1 recall after reset", recall_vals, 0);
        for (int p = 0; p < NP; p++)
            for (int r = 0; r < NR; r++) read_chk(p, r, 0, "R1 slot after reset");

        // directed corners
        frame(0, 3, 3, 63, 1'b1, 0);    // R2 top channel, top slot, all ones
        frame(0, 0, 0, 21, 1'b1, 0);    // R2 and R10 slot 0
        frame(1, 2, 1, 0, 1'b1, 0);     // R7
        frame(2, 0, 0, 0, 1'b1, 0);     // R8 global into slot 0, R10
        frame(2, 0, 2, 0, 1'b1, 0);     // R8
        frame(0, 1, 1, 44, 1'b0, 0);    // R6 protected
        frame(2, 0, 3, 0, 1'b0, 0);     // R6 protected global
        frame(0, 2, 2, 12, 1'b1, 1);    // R3 discarded by new frame
        frame(3, 1, 2, 9, 1'b1, 0);     // R11 no request

        // R9: request during busy is dropped
        cs_fall = 1'b1; step(); cs_fall = 1'b0;
        req_valid = 1'b1; req_kind = 2'd0; req_pot = 2'd1; req_reg = 2'd2; req_data = 6'd7;
        step(); req_valid = 1'b0;
        cs_rise = 1'b1; step(); cs_rise = 1'b0;
        chk(busy == 1'b1, "R9 first commit busy", busy, 1);
        req_valid = 1'b1; req_kind = 2'd0; req_pot = 2'd1; req_reg = 2'd3; req_data = 6'd9;
        step(); req_valid = 1'b0;
        run_busy(1, 2, model[1][2]);
        model[1][2] = 6'd7;
        cs_rise = 1'b1; step(); cs_rise = 1'b0;
        chk(busy == 1'b0, "R9 dropped request no busy", busy, 0);
        read_chk(1, 3, model[1][3], "R9 dropped request slot unchanged");
        read_chk(1, 2, model[1][2], "R9 first commit landed");

        // constrained random frames
        for (int n = 0; n < 40; n++) begin
            int k  = $urandom_range(0, 3);
            bit w  = ($urandom_range(0, 5) != 0);
            int md = ($urandom_range(0, 4) == 0) ? 1 : 0;
            frame(k, $urandom_range(0, 3), $urandom_range(0, 3),
                  $urandom_range(0, 63), w, md);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule